// File: doc/BRIEF.md
# Lockstep Lane Checker with Rollback

This block guards a dual-lane redundant datapath. Four primary lanes each have a fixed partner lane, and when a pair is marked as carrying a duplicated instruction the block compares everything the two lanes are about to commit. Each lane offers a result bus, a destination register index, a register-file write enable and a memory write enable. A disagreement is seen in the same cycle the word reaches the check point. In that cycle the block blocks all register-file and memory writes, pulses a flush, and drives a PC override so that fetch restarts from the saved replay address.

The replay address is kept in a rollback register. It takes the next-PC of each word that commits cleanly, so it always points at the oldest word that has not committed. After a flush, a refill window of a fixed number of cycles follows. During that window writes stay blocked, comparisons are ignored and the rollback register holds its value. The sequencer has two states. ST_RUN checks and commits. ST_REFILL waits out the refill. The transition "rollback" goes from ST_RUN to ST_REFILL on a checked mismatch. The transition "resume" goes from ST_REFILL to ST_RUN when the refill count expires. A saturating rollback counter and a sticky error flag report how many rollbacks have happened.

Top module: `lockstep_rollback_ctrl`

## Requirements
- R1: Lane k (k = 0..3) is compared only with lane k+4. Lanes of different pairs are never compared with each other.
- R2: For an enabled pair, a difference in any one of the result, the destination index, the register-file write enable or the memory write enable alone counts as a mismatch.
- R3: In the cycle a checked mismatch is present in ST_RUN, `rf_wr_block` and `mem_wr_block` are both 1.
- R4: A pair whose bit in `pair_chk_en` is 0 produces no mismatch, whatever its lanes carry.
- R5: When `chk_valid` is 0 no comparison takes effect: there is no flush, no write block and no update of the rollback register.
- R6: `flush` and `pc_override` are 1 for exactly the mismatch cycle. `override_pc` always shows the rollback register.
- R7: The rollback register resets to RESET_PC (0x100 by default). It loads `chk_next_pc` at the clock edge that ends a clean valid word in ST_RUN, and holds its value on a mismatch.
- R8: For the REFILL_CYC (default 5) cycles after a flush, both write blocks stay 1, `flush` stays 0 even when the lanes mismatch, and the rollback register does not change. The cycle after that is back in ST_RUN.
- R9: A mismatch on the replayed word triggers another rollback to the same `override_pc`.
- R10: `err_count` rises by one at the edge that ends each flush cycle and saturates at its all-ones value. `err_sticky` becomes 1 after the first rollback and only reset clears it.
- R11: After reset, `err_count` is 0, `err_sticky` is 0 and no block or flush is asserted while `chk_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_valid | input | 1 | A word is at the check point this cycle |
| chk_next_pc | input | PC_W | Address of the word that follows the one being checked |
| pair_chk_en | input | NPAIR | Per-pair compare enable |
| lane_res | input | 2*NPAIR x RES_W | Lane result buses |
| lane_dst | input | 2*NPAIR x IDX_W | Lane destination register indices |
| lane_rf_we | input | 2*NPAIR | Lane register-file write enables |
| lane_mem_we | input | 2*NPAIR | Lane memory write enables |
| rf_wr_block | output | 1 | Suppress register-file writes |
| mem_wr_block | output | 1 | Suppress memory writes |
| flush | output | 1 | Pipeline flush pulse |
| pc_override | output | 1 | Load `override_pc` into fetch |
| override_pc | output | PC_W | Saved replay address |
| err_count | output | CNT_W | Saturating rollback count |
| err_sticky | output | 1 | Set by any rollback, cleared by reset |

## Verification
If the sequencer state is wrong, the effect shows up at once. A missed transition to ST_REFILL drops the write blocks in the first refill cycle. A late return to ST_RUN keeps them high one cycle too long, which a write-free cycle placed right after the window exposes. A corrupted rollback register appears directly on `override_pc`, which the bench reads after every commit. A wrong pair mapping or a missing field in the comparison shows as a missing or spurious `flush` in the same cycle as the stimulus.

// File: rtl/lockstep_pkg.sv
package lockstep_pkg;
    typedef enum logic [0:0] {
        ST_RUN    = 1'b0,
        ST_REFILL = 1'b1
    } rb_state_t;
endpackage

// File: rtl/lane_pair_cmp.sv
module lane_pair_cmp #(
    parameter int RES_W = 32,
    parameter int IDX_W = 6
) (
    input  logic             chk_en,
    input  logic [RES_W-1:0] res_a,
    input  logic [RES_W-1:0] res_b,
    input  logic [IDX_W-1:0] dst_a,
    input  logic [IDX_W-1:0] dst_b,
    input  logic             rfwe_a,
    input  logic             rfwe_b,
    input  logic             memwe_a,
    input  logic             memwe_b,
    output logic             mism
);
    logic res_diff;
    logic dst_diff;
    logic we_diff;

    always_comb begin
        res_diff = (res_a != res_b);
        dst_diff = (dst_a != dst_b);
        we_diff  = (rfwe_a != rfwe_b) || (memwe_a != memwe_b);
        mism     = chk_en && (res_diff || dst_diff || we_diff);
    end
endmodule

// File: rtl/rollback_seq.sv
module rollback_seq
    import lockstep_pkg::*;
#(
    parameter int              PC_W       = 32,
    parameter int              CNT_W      = 8,
    parameter int              REFILL_CYC = 5,
    parameter logic [PC_W-1:0] RESET_PC   = 'h100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chk_valid,
    input  logic             any_mism,
    input  logic [PC_W-1:0]  next_pc,
    output logic             flush,
    output logic             wr_block,
    output logic [PC_W-1:0]  saved_pc,
    output logic [CNT_W-1:0] err_count,
    output logic             err_sticky
);
    localparam int RC_W = $clog2(REFILL_CYC + 1);
    localparam logic [RC_W-1:0] RC_LOAD = RC_W'(REFILL_CYC - 1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    rb_state_t       state, state_nx;
    logic [RC_W-1:0] rc_q;
    logic            commit_ok;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:    if (chk_valid && any_mism) state_nx = ST_REFILL;
            ST_REFILL: if (rc_q == '0)            state_nx = ST_RUN;
        endcase
    end

    // state register and refill counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RUN;
            rc_q  <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_RUN) rc_q <= RC_LOAD;
            else if (rc_q != '0) rc_q <= rc_q - 1'b1;
        end
    end

    // outputs
    always_comb begin
        flush     = 1'b0;
        wr_block  = 1'b0;
        commit_ok = 1'b0;
        unique case (state)
            ST_RUN: begin
                flush     = chk_valid && any_mism;
                wr_block  = chk_valid && any_mism;
                commit_ok = chk_valid && !any_mism;
            end
            ST_REFILL: begin
                wr_block = 1'b1;
            end
        endcase
    end

    // rollback register and error reporting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            saved_pc   <= RESET_PC;
            err_count  <= '0;
            err_sticky <= 1'b0;
        end else begin
            if (commit_ok) saved_pc <= next_pc;
            if (flush) begin
                err_sticky <= 1'b1;
                if (err_count != CNT_MAX) err_count <= err_count + 1'b1;
            end
        end
    end

    // R6
    flush_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !flush);
    // R8
    refill_pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REFILL) |=> $stable(saved_pc));
    // R7
    commit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && !any_mism && !wr_block && state == ST_RUN) |=> saved_pc == $past(next_pc));
    // R10
    count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> $stable(err_count));
endmodule

// File: rtl/lockstep_rollback_ctrl.sv
module lockstep_rollback_ctrl #(
    parameter int              NPAIR      = 4,
    parameter int              RES_W      = 32,
    parameter int              IDX_W      = 6,
    parameter int              PC_W       = 32,
    parameter int              CNT_W      = 8,
    parameter int              REFILL_CYC = 5,
    parameter logic [PC_W-1:0] RESET_PC   = 'h100
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              chk_valid,
    input  logic [PC_W-1:0]                   chk_next_pc,
    input  logic [NPAIR-1:0]                  pair_chk_en,
    input  logic [2*NPAIR-1:0][RES_W-1:0]     lane_res,
    input  logic [2*NPAIR-1:0][IDX_W-1:0]     lane_dst,
    input  logic [2*NPAIR-1:0]                lane_rf_we,
    input  logic [2*NPAIR-1:0]                lane_mem_we,
    output logic                              rf_wr_block,
    output logic                              mem_wr_block,
    output logic                              flush,
    output logic                              pc_override,
    output logic [PC_W-1:0]                   override_pc,
    output logic [CNT_W-1:0]                  err_count,
    output logic                              err_sticky
);
    logic [NPAIR-1:0] pair_mism;
    logic             any_mism;
    logic             wr_block;

    // pair k: lane k against lane k+NPAIR
    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
        lane_pair_cmp #(.RES_W(RES_W), .IDX_W(IDX_W)) u_cmp (
            .chk_en  (pair_chk_en[k]),
            .res_a   (lane_res[k]),
            .res_b   (lane_res[k+NPAIR]),
            .dst_a   (lane_dst[k]),
            .dst_b   (lane_dst[k+NPAIR]),
            .rfwe_a  (lane_rf_we[k]),
            .rfwe_b  (lane_rf_we[k+NPAIR]),
            .memwe_a (lane_mem_we[k]),
            .memwe_b (lane_mem_we[k+NPAIR]),
            .mism    (pair_mism[k])
        );
    end

    assign any_mism = |pair_mism;

    rollback_seq #(
        .PC_W(PC_W), .CNT_W(CNT_W), .REFILL_CYC(REFILL_CYC), .RESET_PC(RESET_PC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .chk_valid  (chk_valid),
        .any_mism   (any_mism),
        .next_pc    (chk_next_pc),
        .flush      (flush),
        .wr_block   (wr_block),
        .saved_pc   (override_pc),
        .err_count  (err_count),
        .err_sticky (err_sticky)
    );

    assign rf_wr_block  = wr_block;
    assign mem_wr_block = wr_block;
    assign pc_override  = flush;

    // R3
    mism_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && any_mism && !$past(flush)) |-> (rf_wr_block && mem_wr_block) || !$past(rst_n) || $past(wr_block));
    // R8
    refill_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> rf_wr_block && mem_wr_block && !flush);
    // R10
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);
    // R5
    invalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |-> !flush);
endmodule

// File: tb/lockstep_rollback_ctrl_tb.sv
module lockstep_rollback_ctrl_tb;
    localparam int NP = 4;
    localparam int RW = 32;
    localparam int IW = 6;
    localparam int PW = 32;
    localparam int CW = 8;
    localparam int RC = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chk_valid;
    logic [PW-1:0] chk_next_pc;
    logic [NP-1:0] pair_chk_en;
    logic [2*NP-1:0][RW-1:0] lane_res;
    logic [2*NP-1:0][IW-1:0] lane_dst;
    logic [2*NP-1:0] lane_rf_we, lane_mem_we;
    logic rf_wr_block, mem_wr_block, flush, pc_override, err_sticky;
    logic [PW-1:0] override_pc;
    logic [CW-1:0] err_count;

    int n_tests = 0;
    int n_fail = 0;
    int exp_cnt = 0;
    logic [PW-1:0] exp_pc = 32'h100;

    always #4 clk = ~clk;

    lockstep_rollback_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .chk_next_pc(chk_next_pc),
        .pair_chk_en(pair_chk_en), .lane_res(lane_res), .lane_dst(lane_dst),
        .lane_rf_we(lane_rf_we), .lane_mem_we(lane_mem_we),
        .rf_wr_block(rf_wr_block), .mem_wr_block(mem_wr_block), .flush(flush),
        .pc_override(pc_override), .override_pc(override_pc),
        .err_count(err_count), .err_sticky(err_sticky)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // all lanes agree, distinct values across pairs
    task automatic set_clean(logic [PW-1:0] npc);
        chk_valid   = 1'b1;
        chk_next_pc = npc;
        pair_chk_en = '1;
        for (int k = 0; k < NP; k++) begin
            lane_res[k]       = 32'hA000 + k;
            lane_res[k+NP]    = 32'hA000 + k;
            lane_dst[k]       = IW'(k + 1);
            lane_dst[k+NP]    = IW'(k + 1);
            lane_rf_we[k]     = k[0];
            lane_rf_we[k+NP]  = k[0];
            lane_mem_we[k]    = (k == 2);
            lane_mem_we[k+NP] = (k == 2);
        end
    endtask

    task automatic inject(int p, int field);
        case (field)
            0: lane_res[p+NP]    = lane_res[p] ^ 32'h10;
            1: lane_dst[p+NP]    = lane_dst[p] ^ 6'h1;
            2: lane_rf_we[p+NP]  = ~lane_rf_we[p];
            default: lane_mem_we[p+NP] = ~lane_mem_we[p];
        endcase
    endtask

    // inputs driven at negedge, outputs sampled 1 ns later
    task automatic next_cyc();
        @(negedge clk);
    endtask

    // flush cycle already current: step through refill with mismatch present
    task automatic ride_refill(string req);
        for (int c = 0; c < RC; c++) begin
            next_cyc();
            set_clean(32'hDEAD0);
            inject(c % NP, 0);
            #1;
            check({req, " refill block"}, {rf_wr_block, mem_wr_block}, 2'b11);
            check({req, " refill no flush"}, flush, 0);
            check({req, " refill pc hold"}, override_pc, exp_pc);
        end
        next_cyc();
        chk_valid = 1'b0;
        #1;
        check({req, " resume run"}, {rf_wr_block, flush}, 2'b00);
    endtask

    task automatic commit(logic [PW-1:0] npc);
        next_cyc();
        set_clean(npc);
        #1;
        check("R7 clean commit no block", {rf_wr_block, flush}, 2'b00);
        next_cyc();
        chk_valid = 1'b0;
        exp_pc = npc;
        #1;
        check("R7 pc loaded", override_pc, exp_pc);
    endtask

    task automatic t_reset();
        next_cyc();
        chk_valid = 1'b0;
        set_clean(0);
        chk_valid = 1'b0;
        rst_n = 1'b0;
        next_cyc(); next_cyc();
        rst_n = 1'b1;
        exp_pc = 32'h100;
        exp_cnt = 0;
        #1;
        check("R11 count", err_count, 0);
        check("R11 sticky", err_sticky, 0);
        check("R11 blocks", {rf_wr_block, mem_wr_block, flush, pc_override}, 0);
        check("R7 reset pc", override_pc, 32'h100);
    endtask

    task automatic t_pairing();
        next_cyc();
        set_clean(32'h200);
        lane_res[0] = 32'h1; lane_res[4] = 32'h1;
        lane_res[1] = 32'h2; lane_res[5] = 32'h2;
        #1;
        check("R1 cross-pair differ no flush", flush, 0);
        commit(32'h204);
    endtask

    task automatic t_fields();
        for (int f = 0; f < 4; f++) begin
            for (int p = 0; p < NP; p++) begin
                next_cyc();
                set_clean(32'hBAD0);
                inject(p, f);
                #1;
                check("R2 field mismatch flush", flush, 1);
                check("R3 same-cycle blocks", {rf_wr_block, mem_wr_block}, 2'b11);
                check("R6 override pulse", pc_override, 1);
                check("R6 override value", override_pc, exp_pc);
                exp_cnt++;
                ride_refill("R8");
                check("R10 count step", err_count, exp_cnt);
                check("R10 sticky", err_sticky, 1);
            end
        end
    endtask

    task automatic t_disabled();
        for (int p = 0; p < NP; p++) begin
            next_cyc();
            set_clean(32'h300 + 4 * p);
            inject(p, 0);
            inject(p, 3);
            pair_chk_en[p] = 1'b0;
            #1;
            check("R4 disabled pair no flush", {flush, rf_wr_block}, 0);
            next_cyc();
            chk_valid = 1'b0;
            exp_pc = 32'h300 + 4 * p;
            #1;
            check("R4 disabled pair commits", override_pc, exp_pc);
        end
    endtask

    task automatic t_invalid();
        next_cyc();
        set_clean(32'h777);
        inject(1, 0);
        chk_valid = 1'b0;
        #1;
        check("R5 invalid no flush", {flush, rf_wr_block, mem_wr_block}, 0);
        next_cyc();
        set_clean(32'h778);
        chk_valid = 1'b0;
        #1;
        check("R5 invalid no pc load", override_pc, exp_pc);
        check("R5 invalid no count", err_count, exp_cnt);
    endtask

    task automatic t_double();
        commit(32'h400);
        for (int r = 0; r < 2; r++) begin
            next_cyc();
            set_clean(32'h404);
            inject(3, 1);
            #1;
            check("R9 replay flush", flush, 1);
            check("R9 same pc", override_pc, 32'h400);
            exp_cnt++;
            ride_refill("R9");
        end
        check("R10 double count", err_count, exp_cnt);
    endtask

    task automatic t_saturate();
        while (exp_cnt < 256) begin
            next_cyc();
            set_clean(32'h9);
            inject(0, 2);
            #1;
            if (exp_cnt < 255) exp_cnt++;
            else exp_cnt = 256;
            for (int c = 0; c <= RC; c++) next_cyc();
            chk_valid = 1'b0;
        end
        #1;
        check("R10 saturated", err_count, 8'hFF);
        check("R10 sticky held", err_sticky, 1);
    endtask

    initial begin
        set_clean(0);
        chk_valid = 1'b0;
        t_reset();
        t_pairing();
        t_fields();
        t_disabled();
        t_invalid();
        t_double();
        t_saturate();
        t_reset();
        check("R10 sticky cleared by reset", err_sticky, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule